// File: doc/BRIEF.md
# Voice Envelope Generator

This block shapes the loudness of one voice in a sample-playback synthesizer. On every output-sample strobe it moves an 11-bit envelope level (0 to 0x7FF) one step. It follows one of two control schemes. The first is a four-phase attack/decay/sustain/release scheme driven by two configuration bytes. The second is a single gain byte that either sets the level directly or ramps it linearly or exponentially.

Three free-running rate counters are shared by every rate setting. They decide on which samples a newly computed level is committed. A separate, ungated shadow value follows the computation on every sample and steers the bent-line increase mode. Key-on and key-off requests are latched and acted on every second sample. A key-on inserts a short start delay during which the level sits at zero. A soft-reset flag or an end-of-sample flag cuts the voice to silence at once.

Top module: `env_generator`

## Requirements
- R1: After synchronous reset the level is 0, `env_hi` is 0 and the mode is release. Mode encoding: 0 release, 1 attack, 2 decay, 3 sustain.
- R2: Key-on and key-off pulses are held pending and are acted on only at every second sample strobe. The first such strobe is the second one after reset. A pending request seen at any other strobe leaves the mode unchanged.
- R3: An accepted key-on sets attack mode and a level of 0 on that strobe. The level stays 0 for the next four strobes. On the fifth strobe the envelope step runs starting from 0.
- R4: Attack (`cfg_adsr1` bit 7 set) steps by +0x20 at rate 2·A+1, where A is `cfg_adsr1[3:0]`. When A is 15 the step is +0x400 at rate 31. A result above 0x7FF clamps to 0x7FF and switches the mode to decay.
- R5: Decay and sustain compute level−1−((level−1)>>8). Decay uses rate 2·D+16, where D is `cfg_adsr1[6:4]`. Sustain uses rate `cfg_adsr2[4:0]`. Decay becomes sustain on the sample where the result shifted right by 8 equals `cfg_adsr2[7:5]`.
- R6: In release mode the level falls by 8 on every strobe, with no rate gating, and stops at 0. An accepted key-off enters release on the strobe that accepts it.
- R7: With `cfg_adsr1` bit 7 clear and `cfg_gain` bit 7 clear, the level becomes `cfg_gain[6:0]`·16 on every strobe.
- R8: Gain code `cfg_gain[7:5]`=4 subtracts 0x20 per committed step. A negative result clamps to 0. Code 5 applies the exponential fall of R5. Both use rate `cfg_gain[4:0]`.
- R9: Gain code 6 adds 0x20 per step and clamps at 0x7FF. Code 7 adds 0x20 while the shadow value is below 0x600. From then on it adds 8. The shadow value is the unclamped result of the last computed step, updated on every strobe.
- R10: Rate 0 never commits. Rate 31 commits on every strobe. Rate r in 1..29 commits once per (m << (9 − r/3)) strobes, where m is 4, 3 or 5 for r mod 3 equal to 1, 2 or 0. Rate 30 commits once per 2 strobes.
- R11: A strobe with `soft_rst` or `smp_end` high forces release mode and a level of 0 on that strobe.
- R12: Outputs change only on a strobe. `env_hi` always equals level[10:4].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_stb | input | 1 | One-cycle pulse per output sample |
| cfg_adsr1 | input | 8 | Scheme select (bit 7), decay code [6:4], attack code [3:0] |
| cfg_adsr2 | input | 8 | Sustain level [7:5], sustain rate [4:0] |
| cfg_gain | input | 8 | Gain control byte |
| key_on | input | 1 | Key-on request pulse |
| key_off | input | 1 | Key-off request pulse |
| soft_rst | input | 1 | Silence-and-release flag, sampled at strobe |
| smp_end | input | 1 | End of non-looping sample flag, sampled at strobe |
| env_level | output | 11 | Committed envelope level |
| env_mode | output | 2 | Current mode |
| env_hi | output | 8 | Upper level bits for readback |

## Verification
Several rules are checked on every cycle by the bound checker:
- outputs stay stable between strobes;
- a key-on acceptance gives attack at zero, and the start delay holds the level at zero;
- a silence flag gives release at zero;
- release falls by exactly 8;
- direct gain loads its value;
- the fast attack clamps to 0x7FF and enters decay.

The bench's scenarios are the only evidence for the rest: the commit periods of the shared counters at different rates, the acceptance parity of key requests, the exact decay-to-sustain switch point, and the bend of the two-slope increase at 0x600.

// File: rtl/env_gen_pkg.sv
package env_gen_pkg;

  localparam int LVL_W  = 11;
  localparam int RAW_W  = 13;
  localparam int RATE_W = 5;
  localparam int MASK_W = 12;
  localparam logic [LVL_W-1:0] LVL_MAX = '1;

  typedef logic signed [RAW_W-1:0] raw_t;

  typedef enum logic [1:0] {
    ENV_RELEASE = 2'd0,
    ENV_ATTACK  = 2'd1,
    ENV_DECAY   = 2'd2,
    ENV_SUSTAIN = 2'd3
  } env_mode_t;

  // zero-extend a level into the signed working width
  function automatic raw_t widen(input logic [LVL_W-1:0] v);
    return $signed({{(RAW_W-LVL_W){1'b0}}, v});
  endfunction

  // exponential fall: one count, then 1/256 of what is left
  function automatic raw_t exp_fall(input logic [LVL_W-1:0] lvl);
    raw_t t;
    t = widen(lvl) - raw_t'(1);
    return t - (t >>> 8);
  endfunction

  function automatic logic [LVL_W-1:0] clamp_level(input raw_t v);
    if (v < 0) return '0;
    if (v > widen(LVL_MAX)) return LVL_MAX;
    return v[LVL_W-1:0];
  endfunction

  // mask applied to the selected counter; zero result means commit
  function automatic logic [MASK_W-1:0] rate_mask(input logic [RATE_W-1:0] r);
    logic [MASK_W:0] one;
    int sh;
    if (r == RATE_W'(30)) return MASK_W'(1);
    sh  = MASK_W - int'(r) / 3;
    one = (MASK_W+1)'(1) << sh;
    return MASK_W'(one - (MASK_W+1)'(1));
  endfunction

  // which counter (1: base 3, 2: base 4, 3: base 5) serves a rate
  function automatic logic [1:0] rate_bank(input logic [RATE_W-1:0] r);
    if (r == RATE_W'(30)) return 2'd2;
    case (int'(r) % 3)
      1:       return 2'd2;
      2:       return 2'd1;
      default: return 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/env_rate_bank.sv
module env_rate_bank
  import env_gen_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stb,
  input  logic [RATE_W-1:0] rate,
  output logic              tick
);

  localparam int NUM_CNT = 3;

  logic [NUM_CNT:1][CNT_W-1:0] nxt_all;
  logic [CNT_W-1:0]            sel;
  logic [CNT_W-1:0]            msk;

  for (genvar g = 1; g <= NUM_CNT; g++) begin : g_cnt
    localparam logic [CNT_W-1:0] INIT  = (g == 1) ? CNT_W'(0) :
                                         (g == 2) ? ({CNT_W{1'b1}} << 5) : CNT_W'(11);
    localparam logic [CNT_W-1:0] EXTRA = CNT_W'(6 - g);
    logic [CNT_W-1:0] q;

    assign nxt_all[g] = q - CNT_W'(1) - ((q[2:0] == 3'd0) ? EXTRA : CNT_W'(0));

    always_ff @(posedge clk) begin
      if (rst)      q <= INIT;
      else if (stb) q <= nxt_all[g];
    end
  end

  always_comb begin
    case (rate_bank(rate))
      2'd1:    sel = nxt_all[1];
      2'd2:    sel = nxt_all[2];
      default: sel = nxt_all[3];
    endcase
  end

  assign msk  = {{(CNT_W-MASK_W){1'b0}}, rate_mask(rate)};
  assign tick = (rate == '1) | ((rate != '0) & ((sel & msk) == '0));

endmodule

// File: rtl/env_key_seq.sv
module env_key_seq #(
  parameter int START_DLY = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic stb,
  input  logic key_on,
  input  logic key_off,
  output logic take_on,
  output logic take_off,
  output logic in_delay,
  output logic run_env
);

  localparam int DLY_W = $clog2(START_DLY + 1);

  logic             odd_q;
  logic             on_pend;
  logic             off_pend;
  logic [DLY_W-1:0] dly_q;
  logic [DLY_W-1:0] dly_dec;
  logic             sample_keys;

  assign sample_keys = stb & ~odd_q;
  assign take_on     = sample_keys & (on_pend | key_on);
  assign take_off    = sample_keys & (off_pend | key_off);
  assign in_delay    = (dly_q != '0);
  assign dly_dec     = in_delay ? dly_q - DLY_W'(1) : '0;
  assign run_env     = stb & ~take_on & (dly_dec == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      odd_q    <= 1'b1;
      on_pend  <= 1'b0;
      off_pend <= 1'b0;
      dly_q    <= '0;
    end else begin
      if (stb) odd_q <= ~odd_q;
      if (sample_keys) begin
        on_pend  <= 1'b0;
        off_pend <= 1'b0;
      end else begin
        on_pend  <= on_pend | key_on;
        off_pend <= off_pend | key_off;
      end
      if (take_on)  dly_q <= DLY_W'(START_DLY);
      else if (stb) dly_q <= dly_dec;
    end
  end

endmodule

// File: rtl/env_level_calc.sv
module env_level_calc
  import env_gen_pkg::*;
(
  input  env_mode_t         mode,
  input  logic [LVL_W-1:0]  lvl,
  input  raw_t              hid,
  input  logic [7:0]        adsr1,
  input  logic [7:0]        adsr2,
  input  logic [7:0]        gain,
  output logic [RATE_W-1:0] rate,
  output env_mode_t         nxt_mode,
  output raw_t              hid_nxt,
  output logic              gated,
  output logic [LVL_W-1:0]  lvl_res
);

  localparam raw_t STEP_LIN  = raw_t'(32);
  localparam raw_t STEP_FAST = raw_t'(1024);
  localparam raw_t STEP_REL  = raw_t'(8);
  localparam raw_t STEP_BENT = raw_t'(8);
  localparam raw_t BEND_AT   = raw_t'(1536);

  raw_t       raw;
  logic [2:0] slvl;
  logic       adsr_en;

  assign adsr_en = adsr1[7];

  always_comb begin
    rate     = '0;
    raw      = widen(lvl);
    nxt_mode = mode;
    hid_nxt  = hid;
    gated    = 1'b0;
    slvl     = adsr2[7:5];
    if (mode == ENV_RELEASE) begin
      raw = widen(lvl) - STEP_REL;
    end else if (adsr_en && mode == ENV_SUSTAIN) begin
      raw     = exp_fall(lvl);
      rate    = adsr2[4:0];
      hid_nxt = raw;
      gated   = 1'b1;
    end else begin
      if (adsr_en) begin
        if (mode == ENV_DECAY) begin
          raw  = exp_fall(lvl);
          rate = {1'b1, adsr1[6:4], 1'b0};
        end else begin
          rate = {adsr1[3:0], 1'b1};
          raw  = widen(lvl) + ((rate == '1) ? STEP_FAST : STEP_LIN);
        end
      end else begin
        slvl = gain[7:5];
        if (!gain[7]) begin
          raw  = $signed({2'b00, gain[6:0], 4'b0000});
          rate = '1;
        end else begin
          rate = gain[4:0];
          case (gain[6:5])
            2'd0:    raw = widen(lvl) - STEP_LIN;
            2'd1:    raw = exp_fall(lvl);
            2'd2:    raw = widen(lvl) + STEP_LIN;
            default: raw = widen(lvl) + (((hid < 0) || (hid >= BEND_AT)) ? STEP_BENT : STEP_LIN);
          endcase
        end
      end
      if (mode == ENV_DECAY && (raw >>> 8) == $signed({10'd0, slvl}))
        nxt_mode = ENV_SUSTAIN;
      if (mode == ENV_ATTACK && (raw < 0 || raw > widen(LVL_MAX)))
        nxt_mode = ENV_DECAY;
      hid_nxt = raw;
      gated   = 1'b1;
    end
    lvl_res = clamp_level(raw);
  end

endmodule

// File: rtl/env_generator.sv
module env_generator
  import env_gen_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int START_DLY = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_stb,
  input  logic [7:0]       cfg_adsr1,
  input  logic [7:0]       cfg_adsr2,
  input  logic [7:0]       cfg_gain,
  input  logic             key_on,
  input  logic             key_off,
  input  logic             soft_rst,
  input  logic             smp_end,
  output logic [LVL_W-1:0] env_level,
  output logic [1:0]       env_mode,
  output logic [7:0]       env_hi
);

  env_mode_t         mode_q, mode_k, nxt_mode;
  logic [LVL_W-1:0]  lvl_q, lvl_k, lvl_b, lvl_res;
  raw_t              hid_q, hid_b, hid_nxt;
  logic [RATE_W-1:0] rate;
  logic              tick, gated, commit, kill;
  logic              take_on, take_off, in_delay, run_env;

  env_key_seq #(.START_DLY(START_DLY)) u_keys (
    .clk(clk), .rst(rst), .stb(smp_stb), .key_on(key_on), .key_off(key_off),
    .take_on(take_on), .take_off(take_off), .in_delay(in_delay), .run_env(run_env)
  );

  env_rate_bank #(.CNT_W(CNT_W)) u_rates (
    .clk(clk), .rst(rst), .stb(smp_stb), .rate(rate), .tick(tick)
  );

  assign kill  = soft_rst | smp_end;
  assign lvl_b = in_delay ? '0 : lvl_q;
  assign hid_b = in_delay ? '0 : hid_q;

  always_comb begin
    mode_k = mode_q;
    lvl_k  = lvl_b;
    if (kill) begin
      mode_k = ENV_RELEASE;
      lvl_k  = '0;
    end
    if (take_off) mode_k = ENV_RELEASE;
    if (take_on) begin
      mode_k = ENV_ATTACK;
      lvl_k  = '0;
    end
  end

  env_level_calc u_calc (
    .mode(mode_k), .lvl(lvl_k), .hid(hid_b),
    .adsr1(cfg_adsr1), .adsr2(cfg_adsr2), .gain(cfg_gain),
    .rate(rate), .nxt_mode(nxt_mode), .hid_nxt(hid_nxt),
    .gated(gated), .lvl_res(lvl_res)
  );

  assign commit = ~gated | tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= ENV_RELEASE;
      lvl_q  <= '0;
      hid_q  <= '0;
    end else if (smp_stb) begin
      mode_q <= run_env ? nxt_mode : mode_k;
      hid_q  <= run_env ? hid_nxt : (take_on ? raw_t'(0) : hid_b);
      lvl_q  <= (run_env && commit) ? lvl_res : lvl_k;
    end
  end

  assign env_level = lvl_q;
  assign env_mode  = mode_q;
  assign env_hi    = {1'b0, lvl_q[LVL_W-1:4]};

endmodule

// File: rtl/env_generator_chk.sv
module env_generator_chk
  import env_gen_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             smp_stb,
  input logic             kill,
  input logic             take_on,
  input logic             take_off,
  input logic             in_delay,
  input logic             run_env,
  input logic [7:0]       cfg_adsr1,
  input logic [7:0]       cfg_gain,
  input logic [LVL_W-1:0] env_level,
  input logic [1:0]       env_mode
);

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !smp_stb |=> ($stable(env_level) && $stable(env_mode))); // R12

  AST_KEYON_ATTACK: assert property (@(posedge clk) disable iff (rst)
    (smp_stb && take_on) |=> (env_mode == 2'd1 && env_level == '0)); // R3

  AST_HOLD_DELAY: assert property (@(posedge clk) disable iff (rst)
    (smp_stb && in_delay && !run_env) |=> (env_level == '0)); // R3

  AST_KILL_ZERO: assert property (@(posedge clk) disable iff (rst)
    (smp_stb && kill && !take_on) |=> (env_level == '0 && env_mode == 2'd0)); // R11

  AST_RELEASE_STEP: assert property (@(posedge clk) disable iff (rst)
    (smp_stb && run_env && !in_delay && !kill && env_mode == 2'd0)
    |=> (env_level == (($past(env_level) > 11'd8) ? $past(env_level) - 11'd8 : 11'd0))); // R6

  AST_GAIN_DIRECT: assert property (@(posedge clk) disable iff (rst)
    (smp_stb && run_env && !kill && !take_off && env_mode != 2'd0 && !cfg_adsr1[7] && !cfg_gain[7])
    |=> (env_level == {$past(cfg_gain[6:0]), 4'b0000})); // R7

  AST_ATTACK_CLAMP: assert property (@(posedge clk) disable iff (rst)
    (smp_stb && run_env && !in_delay && !kill && !take_off && env_mode == 2'd1 &&
     cfg_adsr1[7] && cfg_adsr1[3:0] == 4'hF && env_level >= 11'h400)
    |=> (env_level == 11'h7FF && env_mode == 2'd2)); // R4

endmodule

bind env_generator env_generator_chk u_chk (
  .clk(clk), .rst(rst), .smp_stb(smp_stb), .kill(kill),
  .take_on(take_on), .take_off(take_off), .in_delay(in_delay), .run_env(run_env),
  .cfg_adsr1(cfg_adsr1), .cfg_gain(cfg_gain),
  .env_level(env_level), .env_mode(env_mode)
);

// File: tb/test_env_generator.sv
`timescale 1ns/1ps
module test_env_generator;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smp_stb = 1'b0;
  logic [7:0]  cfg_adsr1 = '0;
  logic [7:0]  cfg_adsr2 = '0;
  logic [7:0]  cfg_gain = '0;
  logic        key_on = 1'b0;
  logic        key_off = 1'b0;
  logic        soft_rst = 1'b0;
  logic        smp_end = 1'b0;
  logic [10:0] env_level;
  logic [1:0]  env_mode;
  logic [7:0]  env_hi;

  int checks = 0;
  int fails  = 0;
  int nstb   = 0;

  always #2.5 clk = ~clk;

  env_generator i_env_generator (
    .clk(clk), .rst(rst), .smp_stb(smp_stb),
    .cfg_adsr1(cfg_adsr1), .cfg_adsr2(cfg_adsr2), .cfg_gain(cfg_gain),
    .key_on(key_on), .key_off(key_off), .soft_rst(soft_rst), .smp_end(smp_end),
    .env_level(env_level), .env_mode(env_mode), .env_hi(env_hi)
  );

  task automatic chk(input string req, input int act, input int want);
    checks++;
    if (act != want) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, want);
    end
  endtask

  task automatic strobe();
    @(negedge clk) smp_stb = 1'b1;
    @(negedge clk) smp_stb = 1'b0;
    nstb++;
  endtask

  task automatic pulse_on();
    @(negedge clk) key_on = 1'b1;
    @(negedge clk) key_on = 1'b0;
  endtask

  task automatic pulse_off();
    @(negedge clk) key_off = 1'b1;
    @(negedge clk) key_off = 1'b0;
  endtask

  // strobe until the key request is taken (even strobe count)
  task automatic strobe_to_accept();
    strobe();
    while (nstb % 2 != 0) strobe();
  endtask

  task automatic keyon_run();
    pulse_on();
    strobe_to_accept();
    repeat (5) strobe();
  endtask

  task automatic measure_gap(input string req, input int period);
    logic [10:0] prev;
    int n;
    prev = env_level;
    n = 0;
    while (env_level == prev && n < 5000) begin strobe(); n++; end
    for (int k = 0; k < 2; k++) begin
      prev = env_level;
      n = 0;
      do begin strobe(); n++; end while (env_level == prev && n < 5000);
      chk(req, n, period);
    end
  endtask

  task automatic t_reset();
    chk("R1 level", env_level, 0);
    chk("R1 mode", env_mode, 0);
    chk("R1 hi", env_hi, 0);
  endtask

  task automatic t_keyon_attack();
    cfg_adsr1 = 8'h8F;
    cfg_adsr2 = 8'hFC;
    pulse_on();
    strobe_to_accept();
    chk("R3 accept level", env_level, 0);
    chk("R3 accept mode", env_mode, 1);
    for (int i = 0; i < 4; i++) begin
      strobe();
      chk("R3 delay level", env_level, 0);
    end
    strobe();
    chk("R4 fast attack step", env_level, 'h400);
    strobe();
    chk("R4 attack clamp", env_level, 'h7FF);
    chk("R4 attack to decay", env_mode, 2);
    chk("R12 hi byte", env_hi, 'h7F);
    strobe();
    chk("R5 decay to sustain", env_mode, 3);
    measure_gap("R5 sustain rate 28", 4);
    chk("R5 still sustain", env_mode, 3);
  endtask

  task automatic t_keyoff();
    logic [10:0] l;
    pulse_off();
    do begin l = env_level; strobe(); end while (nstb % 2 != 0);
    chk("R6 key-off mode", env_mode, 0);
    chk("R6 release step", env_level, (l > 8) ? l - 8 : 0);
    l = env_level;
    strobe();
    chk("R6 release step 2", env_level, (l > 8) ? l - 8 : 0);
  endtask

  task automatic t_key_parity();
    if (nstb % 2 != 0) strobe();
    cfg_adsr1 = 8'h00;
    cfg_gain  = 8'h00;
    pulse_on();
    strobe();
    chk("R2 odd strobe ignores key-on", env_mode, 0);
    strobe();
    chk("R2 even strobe takes key-on", env_mode, 1);
    repeat (5) strobe();
  endtask

  task automatic t_release_floor();
    cfg_adsr1 = 8'h00;
    cfg_gain  = 8'h01;
    keyon_run();
    chk("R7 direct 0x01", env_level, 'h10);
    pulse_off();
    strobe_to_accept();
    chk("R6 release from 0x10", env_level, 'h08);
    strobe();
    chk("R6 release floor", env_level, 0);
    strobe();
    chk("R6 release holds 0", env_level, 0);
  endtask

  task automatic t_gain_modes();
    cfg_adsr1 = 8'h00;
    cfg_gain  = 8'h55;
    keyon_run();
    chk("R7 direct 0x55", env_level, 'h550);
    cfg_gain = 8'h2A; strobe();
    chk("R7 direct 0x2A", env_level, 'h2A0);
    cfg_gain = 8'h03; strobe();
    cfg_gain = 8'h9F; strobe();
    chk("R8 linear down", env_level, 'h010);
    strobe();
    chk("R8 linear down clamps 0", env_level, 0);
    strobe();
    chk("R8 stays 0", env_level, 0);
    cfg_gain = 8'h55; strobe();
    cfg_gain = 8'hBF; strobe();
    chk("R8 exp down 1", env_level, 'h54A);
    strobe();
    chk("R8 exp down 2", env_level, 'h544);
    cfg_gain = 8'h7E; strobe();
    cfg_gain = 8'hDF; strobe();
    chk("R9 linear up clamp", env_level, 'h7FF);
    strobe();
    chk("R9 holds top", env_level, 'h7FF);
  endtask

  task automatic t_two_slope();
    cfg_adsr1 = 8'h00;
    cfg_gain  = 8'h00;
    keyon_run();
    strobe();
    cfg_gain = 8'hFF;
    repeat (48) strobe();
    chk("R9 bent rise reaches 0x600", env_level, 'h600);
    strobe();
    chk("R9 slow slope 1", env_level, 'h608);
    strobe();
    chk("R9 slow slope 2", env_level, 'h610);
  endtask

  task automatic rate_case(input logic [4:0] r, input int period);
    cfg_gain = 8'h00; strobe();
    cfg_gain = {3'b110, r};
    measure_gap($sformatf("R10 rate %0d", r), period);
  endtask

  task automatic t_rates();
    logic [10:0] l;
    cfg_adsr1 = 8'h00;
    cfg_gain  = 8'h00;
    keyon_run();
    rate_case(5'd31, 1);
    rate_case(5'd30, 2);
    rate_case(5'd28, 4);
    rate_case(5'd26, 6);
    rate_case(5'd22, 16);
    rate_case(5'd13, 128);
    cfg_gain = 8'h00; strobe();
    cfg_gain = 8'hC0;
    l = env_level;
    repeat (40) strobe();
    chk("R10 rate 0 never commits", env_level, l);
    cfg_adsr1 = 8'h8E;
    cfg_adsr2 = 8'h00;
    keyon_run();
    measure_gap("R4 attack rate 29", 3);
    chk("R4 attack step 0x20", env_level % 'h20, 0);
    cfg_adsr1 = 8'hFF;
    cfg_adsr2 = 8'h1F;
    keyon_run();
    strobe();
    chk("R5 decay entered", env_mode, 2);
    measure_gap("R5 decay rate 30", 2);
  endtask

  task automatic t_kill();
    soft_rst = 1'b1; strobe(); soft_rst = 1'b0;
    chk("R11 soft reset level", env_level, 0);
    chk("R11 soft reset mode", env_mode, 0);
    cfg_adsr1 = 8'h00;
    cfg_gain  = 8'h40;
    keyon_run();
    chk("R7 direct 0x40", env_level, 'h400);
    smp_end = 1'b1; strobe(); smp_end = 1'b0;
    chk("R11 end flag level", env_level, 0);
    chk("R11 end flag mode", env_mode, 0);
  endtask

  task automatic t_idle();
    cfg_adsr1 = 8'h00;
    cfg_gain  = 8'h40;
    keyon_run();
    cfg_gain = 8'h7F;
    repeat (10) @(negedge clk);
    chk("R12 no change without strobe", env_level, 'h400);
    chk("R12 hi byte 0x40", env_hi, 'h40);
    strobe();
    chk("R12 change on strobe", env_level, 'h7F0);
    chk("R12 hi byte 0x7F", env_hi, 'h7F);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_keyon_attack();
    t_keyoff();
    t_key_parity();
    t_release_floor();
    t_gain_modes();
    t_two_slope();
    t_rates();
    t_kill();
    t_idle();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout, expected run completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule